// File: doc/BRIEF.md
# Zero Common-Mode PWM Pattern Generator

This block drives the three phase legs of an odd-level (n-level) inverter so that the sum of the three output levels, and with it the common-mode voltage, stays fixed at 3(n-1)/2 at every instant. Once per sampling period it takes three signed fixed-point references, normalised to the dc-source voltage. It shifts each reference up by (n-1)/2 and splits the result into an integer base level and a fractional active duty. From the base levels it derives the active-state sum, which is 1 or 2.

A triangular carrier spans one sampling period, running from its valley to its peak and back. Two phases, called s1 and s2, are each compared against the carrier once, so each switches in a single pulse. The third phase, called d, carries whatever active bit keeps the active sum constant, so it switches twice. Which phase takes which role comes from a selector outside this block through a 3-bit mapping code. The code is captured together with the references at the start of each period.

Each phase output is an integer level code: its base level plus its active bit. A pattern flag reports the active sum. A fault flag marks periods and instants that the two patterns cannot serve.

Top module: `zcm_pwm_gen`

## Requirements
- R1: While rst_ni is low, all three level outputs, pat_o and fault_o are 0, whatever the inputs.
- R2: The normalised reference is v = ref + (n-1)/2. The reference has FRAC_W fractional bits. The base level is floor(v), except that v exactly equal to n-1 gives base n-2 with active duty 1.0. The active duty is v minus the base level.
- R3: The active sum is fe = 3(n-1)/2 minus the sum of the three base levels. pat_o is 0 for fe = 1 and 1 for fe = 2, and is held for the whole period.
- R4: The carrier value is c = k/2^CAR_BITS. Over one period of 2*2^CAR_BITS cycles, k runs 0, 1, ..., 2^CAR_BITS-1, then 2^CAR_BITS-1 down to 0, one step per clock. The period starts on the cycle after the load edge. The s1 phase has active bit 1 exactly when c >= 1 - duty(s1).
- R5: The s2 phase has active bit 1 exactly when c < duty(s2).
- R6: The d phase has active bit 1 exactly when fe - bit(s1) - bit(s2) equals 1. In a fault-free cycle, the number of set active bits equals fe.
- R7: In a fault-free period, each level output equals its base level plus its active bit, and the three levels sum to 3(n-1)/2 in every cycle.
- R8: Mapping code: bits [1:0] select the d phase (0 = A, 1 = B, 2 = C). With bit 2 = 0, s1 is the phase that follows d in the cyclic order A, B, C and s2 is the phase after that; bit 2 = 1 swaps s1 and s2.
- R9: References and mapping are sampled only on the last cycle of a period (carrier valley, falling side) and on the first edge after reset. Changes at other times do not affect the outputs until the next period.
- R10: A period is faulted if fe is not 1 or 2, if mapping bits [1:0] equal 3, or if any v lies outside [0, n-1]. In a faulted period fault_o is 1 and all levels and pat_o are 0 for the whole period.
- R11: In a period that is not faulted, fault_o is 1 in exactly those cycles where fe - bit(s1) - bit(s2) is neither 0 nor 1. In those cycles the d active bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | INT_W+FRAC_W | Phase A reference, signed, normalised to dc-source voltage |
| ref_b_i | input | INT_W+FRAC_W | Phase B reference |
| ref_c_i | input | INT_W+FRAC_W | Phase C reference |
| map_i | input | 3 | Phase-to-sequence mapping code |
| lvl_a_o | output | clog2(N_LEVELS) | Phase A output level |
| lvl_b_o | output | clog2(N_LEVELS) | Phase B output level |
| lvl_c_o | output | clog2(N_LEVELS) | Phase C output level |
| pat_o | output | 1 | 0: active sum 1, 1: active sum 2 |
| fault_o | output | 1 | Faulted period or inconsistent d-phase instant |

## Verification
The bench sweeps a grid of zero-sum reference triples and a set of irregular fractions under every valid mapping code. It checks each phase in every carrier cycle against an arithmetic model.

It aims at the following corners, and at what a wrong design would do in each:
- A reference exactly at the top rail: floor without the n-2 exception would emit an out-of-range level.
- References landing exactly on integers: these give the pivot case fe = 0, which must raise the fault instead of producing a level sum one short.
- Carrier samples at the peak and at the valley: an off-by-one in the compare or the carrier turn shifts an edge by one cycle.
- Swapped mapping codes: a wrong decode moves the double pulse onto the wrong phase.
- References changed mid-period: these must not leak into the current period.
- References that do not sum to zero: these must expose an impossible d bit through fault_o.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
  typedef logic [1:0] phase_t;

  function automatic phase_t next_phase(phase_t p);
    return (p == phase_t'(2)) ? phase_t'(0) : phase_t'(p + phase_t'(1));
  endfunction
endpackage

// File: rtl/zcm_phase_split.sv
module zcm_phase_split #(
  parameter int N_LEVELS = 5,
  parameter int FRAC_W   = 16,
  parameter int INT_W    = 4
) (
  input  logic signed [INT_W+FRAC_W-1:0] ref_i,
  output logic [$clog2(N_LEVELS)-1:0]    base_o,
  output logic [FRAC_W:0]                duty_o,
  output logic                           range_ok_o
);
  localparam int REF_W = INT_W + FRAC_W;
  localparam int V_W   = REF_W + 1;
  localparam int LVL_W = $clog2(N_LEVELS);
  localparam logic signed [V_W-1:0] OFS   = V_W'(((N_LEVELS - 1) / 2) * (2 ** FRAC_W));
  localparam logic signed [V_W-1:0] TOP_V = V_W'((N_LEVELS - 1) * (2 ** FRAC_W));
  localparam logic [FRAC_W:0]       ONE   = (FRAC_W+1)'(1) << FRAC_W;

  logic signed [V_W-1:0] v;
  logic                  top_hit;

  assign v          = $signed({ref_i[REF_W-1], ref_i}) + OFS;
  assign top_hit    = (v == TOP_V);
  assign range_ok_o = !v[V_W-1] && (v <= TOP_V);

  // top rail keeps the base one level below the maximum
  always_comb begin
    if (top_hit) begin
      base_o = LVL_W'(N_LEVELS - 2);
      duty_o = ONE;
    end else begin
      base_o = v[FRAC_W +: LVL_W];
      duty_o = {1'b0, v[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/zcm_carrier.sv
module zcm_carrier #(
  parameter int CAR_BITS = 4,
  parameter int FRAC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [FRAC_W-1:0] car_o,
  output logic              load_o
);
  localparam logic [CAR_BITS-1:0] CNT_MAX = '1;

  logic [CAR_BITS-1:0] cnt_q;
  logic                down_q;

  assign load_o = down_q && (cnt_q == '0);
  assign car_o  = FRAC_W'(cnt_q) << (FRAC_W - CAR_BITS);

  // reset parks at the valley so the first edge loads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b1;
    end else if (load_o) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!down_q) begin
      if (cnt_q == CNT_MAX) down_q <= 1'b1;
      else                  cnt_q  <= cnt_q + CAR_BITS'(1);
    end else begin
      cnt_q <= cnt_q - CAR_BITS'(1);
    end
  end

  // R4
  carrier_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CAR_BITS'(1)
              || cnt_q == $past(cnt_q) - CAR_BITS'(1)));

  // R4
  carrier_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!down_q && cnt_q == CNT_MAX) |=> (down_q && cnt_q == CNT_MAX));
endmodule

// File: rtl/zcm_pwm_gen.sv
module zcm_pwm_gen
  import zcm_pkg::*;
#(
  parameter int N_LEVELS = 5,
  parameter int FRAC_W   = 16,
  parameter int INT_W    = 4,
  parameter int CAR_BITS = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic signed [INT_W+FRAC_W-1:0]  ref_a_i,
  input  logic signed [INT_W+FRAC_W-1:0]  ref_b_i,
  input  logic signed [INT_W+FRAC_W-1:0]  ref_c_i,
  input  logic [2:0]                      map_i,
  output logic [$clog2(N_LEVELS)-1:0]     lvl_a_o,
  output logic [$clog2(N_LEVELS)-1:0]     lvl_b_o,
  output logic [$clog2(N_LEVELS)-1:0]     lvl_c_o,
  output logic                            pat_o,
  output logic                            fault_o
);
  localparam int REF_W    = INT_W + FRAC_W;
  localparam int LVL_W    = $clog2(N_LEVELS);
  localparam int DUTY_W   = FRAC_W + 1;
  localparam int SUM_W    = LVL_W + 2;
  localparam int HALF_SUM = 3 * (N_LEVELS - 1) / 2;
  localparam logic [DUTY_W-1:0] ONE = DUTY_W'(1) << FRAC_W;

  logic signed [REF_W-1:0] ref_w   [3];
  logic [LVL_W-1:0]        base_w  [3];
  logic [DUTY_W-1:0]       duty_w  [3];
  logic [2:0]              rng_ok_w;

  assign ref_w[0] = ref_a_i;
  assign ref_w[1] = ref_b_i;
  assign ref_w[2] = ref_c_i;

  for (genvar g = 0; g < 3; g++) begin : g_split
    zcm_phase_split #(.N_LEVELS(N_LEVELS), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_split (
      .ref_i      (ref_w[g]),
      .base_o     (base_w[g]),
      .duty_o     (duty_w[g]),
      .range_ok_o (rng_ok_w[g])
    );
  end

  logic [FRAC_W-1:0] car_w;
  logic              load_w;

  zcm_carrier #(.CAR_BITS(CAR_BITS), .FRAC_W(FRAC_W)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .car_o  (car_w),
    .load_o (load_w)
  );

  // active sum from the base levels
  logic [SUM_W-1:0]      base_sum;
  logic signed [SUM_W:0] fe_w;
  logic                  fe_ok;

  assign base_sum = SUM_W'(base_w[0]) + SUM_W'(base_w[1]) + SUM_W'(base_w[2]);
  assign fe_w     = $signed((SUM_W+1)'(HALF_SUM)) - $signed({1'b0, base_sum});
  assign fe_ok    = (fe_w == (SUM_W+1)'(1)) || (fe_w == (SUM_W+1)'(2));

  // mapping decode
  phase_t d_in, s1_in, s2_in;
  logic   map_ok;

  assign d_in   = phase_t'(map_i[1:0]);
  assign map_ok = (d_in != phase_t'(3));
  assign s1_in  = map_i[2] ? next_phase(next_phase(d_in)) : next_phase(d_in);
  assign s2_in  = map_i[2] ? next_phase(d_in) : next_phase(next_phase(d_in));

  // per-period state
  logic [LVL_W-1:0]  base_q [3];
  logic [DUTY_W-1:0] duty_q [3];
  phase_t            d_q, s1_q, s2_q;
  logic              pat2_q, seq_flt_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < 3; p++) begin
        base_q[p] <= '0;
        duty_q[p] <= '0;
      end
      d_q       <= '0;
      s1_q      <= '0;
      s2_q      <= '0;
      pat2_q    <= 1'b0;
      seq_flt_q <= 1'b0;
      valid_q   <= 1'b0;
    end else if (load_w) begin
      for (int p = 0; p < 3; p++) begin
        base_q[p] <= base_w[p];
        duty_q[p] <= duty_w[p];
      end
      d_q       <= d_in;
      s1_q      <= s1_in;
      s2_q      <= s2_in;
      pat2_q    <= (fe_w == (SUM_W+1)'(2));
      seq_flt_q <= !(&rng_ok_w) || !fe_ok || !map_ok;
      valid_q   <= 1'b1;
    end
  end

  // carrier comparisons
  logic [DUTY_W-1:0] duty1, duty2, car_x;
  logic              b1, b2, bd, d_bad, run;
  logic [2:0]        dsum;
  logic [2:0]        act;
  logic [LVL_W-1:0]  lvl [3];

  always_comb begin
    duty1 = '0;
    duty2 = '0;
    for (int p = 0; p < 3; p++) begin
      if (s1_q == phase_t'(p)) duty1 = duty_q[p];
      if (s2_q == phase_t'(p)) duty2 = duty_q[p];
    end
  end

  assign car_x = {1'b0, car_w};
  assign b1    = (car_x >= ONE - duty1);
  assign b2    = (car_x < duty2);
  assign dsum  = (pat2_q ? 3'd2 : 3'd1) - 3'(b1) - 3'(b2);
  assign bd    = (dsum == 3'd1);
  assign d_bad = (dsum > 3'd1);  // 2, or -1 wrapped
  assign run   = valid_q && !seq_flt_q;

  always_comb begin
    for (int p = 0; p < 3; p++) begin
      act[p] = run && ((s1_q == phase_t'(p) && b1) || (s2_q == phase_t'(p) && b2)
                       || (d_q == phase_t'(p) && bd));
      lvl[p] = run ? base_q[p] + LVL_W'(act[p]) : '0;
    end
  end

  assign lvl_a_o = lvl[0];
  assign lvl_b_o = lvl[1];
  assign lvl_c_o = lvl[2];
  assign pat_o   = run && pat2_q;
  assign fault_o = valid_q && (seq_flt_q || d_bad);

  // R7
  level_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !fault_o) |->
      (SUM_W'(lvl_a_o) + SUM_W'(lvl_b_o) + SUM_W'(lvl_c_o) == SUM_W'(HALF_SUM)));

  // R6
  act_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !fault_o) |-> ($countones(act) == (pat_o ? 2 : 1)));

  // R3
  pat1_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !fault_o && !pat_o) |-> !(b1 && b2));

  // R10
  map_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && map_i[1:0] == 2'd3) |=> fault_o);

  // R9
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_w |=> $stable(pat_o));
endmodule

// File: tb/sim_zcm_pwm_gen.sv
module sim_zcm_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 5;
  localparam int FW   = 16;
  localparam int IW   = 4;
  localparam int CB   = 4;
  localparam int H    = 1 << CB;
  localparam int PER  = 2 * H;
  localparam int ONE  = 1 << FW;
  localparam int HSUM = 3 * (N - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [IW+FW-1:0] ref_a, ref_b, ref_c;
  logic [2:0] map;
  logic [2:0] lvl_a, lvl_b, lvl_c;
  logic pat, fault;

  int errors = 0;
  int checks = 0;
  int e_base[3];
  int e_duty[3];
  int e_fe, e_s1, e_s2, e_d;
  bit e_seqf;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcm_pwm_gen #(.N_LEVELS(N), .FRAC_W(FW), .INT_W(IW), .CAR_BITS(CB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_a_i(ref_a), .ref_b_i(ref_b), .ref_c_i(ref_c),
    .map_i(map), .lvl_a_o(lvl_a), .lvl_b_o(lvl_b), .lvl_c_o(lvl_c),
    .pat_o(pat), .fault_o(fault)
  );

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  task automatic drive(int r0, int r1, int r2, int m);
    ref_a = r0[IW+FW-1:0];
    ref_b = r1[IW+FW-1:0];
    ref_c = r2[IW+FW-1:0];
    map   = m[2:0];
  endtask

  // expected period state from R2, R3, R8, R10
  task automatic prep(int r0, int r1, int r2, int m);
    int r[3];
    int v, bsum;
    r[0] = r0; r[1] = r1; r[2] = r2;
    e_seqf = 1'b0;
    bsum = 0;
    for (int p = 0; p < 3; p++) begin
      v = r[p] + ((N - 1) / 2) * ONE;
      if (v < 0 || v > (N - 1) * ONE) e_seqf = 1'b1;
      e_base[p] = (v == (N - 1) * ONE) ? N - 2 : (v >>> FW);
      e_duty[p] = v - e_base[p] * ONE;
      bsum += e_base[p];
    end
    e_fe = HSUM - bsum;
    if (e_fe < 1 || e_fe > 2) e_seqf = 1'b1;
    e_d = m & 3;
    if (e_d == 3) begin
      e_seqf = 1'b1;
      e_s1 = 0;
      e_s2 = 1;
    end else begin
      e_s1 = ((m & 4) != 0) ? (e_d + 2) % 3 : (e_d + 1) % 3;
      e_s2 = 3 - e_d - e_s1;
    end
  endtask

  // one sampling period, sampled at negedges; mid != 0 changes inputs inside it (R9)
  task automatic run_period(string tag, bit mid);
    int k, c, b1, b2, ds, bd, dyn;
    int got[3];
    int ex[3];
    string role;
    for (int j = 0; j < PER; j++) begin
      @(negedge clk);
      k  = (j < H) ? j : PER - 1 - j;
      c  = k << (FW - CB);
      b1 = (c >= ONE - e_duty[e_s1]) ? 1 : 0;
      b2 = (c < e_duty[e_s2]) ? 1 : 0;
      ds = e_fe - b1 - b2;
      bd = (ds == 1) ? 1 : 0;
      dyn = (ds < 0 || ds > 1) ? 1 : 0;
      got[0] = int'(lvl_a); got[1] = int'(lvl_b); got[2] = int'(lvl_c);
      for (int p = 0; p < 3; p++) begin
        if (e_seqf) ex[p] = 0;
        else ex[p] = e_base[p] + ((p == e_s1) ? b1 : (p == e_s2) ? b2 : bd);
        if (e_seqf) role = "R10";
        else if (p == e_s1) role = "R4";
        else if (p == e_s2) role = "R5";
        else role = "R6";
        chk({tag, "/", role}, $sformatf("lvl phase %0d cyc %0d", p, j), got[p], ex[p]);
      end
      chk({tag, e_seqf ? "/R10" : "/R3"}, $sformatf("pat cyc %0d", j), int'(pat),
          (!e_seqf && e_fe == 2) ? 1 : 0);
      chk({tag, e_seqf ? "/R10" : "/R11"}, $sformatf("fault cyc %0d", j), int'(fault),
          e_seqf ? 1 : dyn);
      if (mid && j == 7) drive(3 * ONE, 0, -ONE, 3);
    end
  endtask

  task automatic period(string tag, int r0, int r1, int r2, int m, bit mid);
    drive(r0, r1, r2, m);
    prep(r0, r1, r2, m);
    run_period(tag, mid);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vmap[6];
    int a, b, cc, idx;
    vmap = '{0, 1, 2, 4, 5, 6};

    // R1: outputs held low in reset, with inputs that would fault
    drive(3 * ONE, 0, 0, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "lvl_a reset", int'(lvl_a), 0);
      chk("R1", "lvl_b reset", int'(lvl_b), 0);
      chk("R1", "lvl_c reset", int'(lvl_c), 0);
      chk("R1", "pat reset", int'(pat), 0);
      chk("R1", "fault reset", int'(fault), 0);
    end
    rst_n = 1'b1;

    // R2: top rail (v = n-1) and bottom rail (v = 0)
    period("R2", 2 * ONE, -ONE, -ONE, 1, 1'b0);
    period("R2", 2 * ONE, -ONE, -ONE, 0, 1'b0);
    period("R2", -2 * ONE, ONE + ONE / 2, ONE / 2 - ONE, 4, 1'b0);

    // R8: every valid mapping on a pattern-1 and a pattern-2 triple
    for (int i = 0; i < 6; i++) period("R8", 19661, 13107, -32768, vmap[i], 1'b0);
    for (int i = 0; i < 6; i++) period("R8", 45875, 52429, -98304, vmap[i], 1'b0);

    // R9: inputs changed mid-period
    period("R9", 19661, 13107, -32768, 5, 1'b1);
    period("R9", 45875, 52429, -98304, 2, 1'b1);

    // R10: invalid map codes, out-of-range reference, pivot sum
    period("R10", 19661, 13107, -32768, 3, 1'b0);
    period("R10", 19661, 13107, -32768, 7, 1'b0);
    period("R10", 3 * ONE, -ONE, -2 * ONE, 0, 1'b0);
    period("R10", 0, ONE, -ONE, 0, 1'b0);

    // R11: references that do not sum to zero
    period("R11", 49152, 49152, -ONE, 2, 1'b0);
    period("R11", 16384, 16384, -ONE + 8192, 6, 1'b0);

    // R7: quarter-step grid of zero-sum triples
    idx = 0;
    for (int ia = -8; ia <= 8; ia++) begin
      for (int ib = -8; ib <= 8; ib++) begin
        if (ia + ib >= -8 && ia + ib <= 8) begin
          period("R7", ia * (ONE / 4), ib * (ONE / 4), -(ia + ib) * (ONE / 4),
                 vmap[idx % 6], 1'b0);
          idx++;
        end
      end
    end

    // R7: irregular fractions
    for (int i = 1; i <= 150; i++) begin
      a  = ((i * 102953) % (3 * ONE)) - 3 * ONE / 2;
      b  = ((i * 71993 + 5077) % (3 * ONE)) - 3 * ONE / 2;
      cc = -(a + b);
      if (cc >= -2 * ONE && cc <= 2 * ONE) period("R7", a, b, cc, vmap[i % 6], 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule